// File: doc/BRIEF.md
# Legacy Interrupt Pending and Enable Register

This block is one 32-bit control word that gathers the four level-sensitive legacy interrupt lines of a parallel PCI bus (INTA to INTD) into a single interrupt for a parent interrupt controller. Each line has a pending bit and an enable bit in the same word. A pending bit is set while its line is high, whether or not the line is enabled. Software clears a pending bit by writing a 1 to it. The combined output is the registered OR of every pending line that is also enabled.

The word also holds error-interrupt enables and bus-master request priority bits. The block stores these and gives them back on reads, and nothing else. Software writes the word through a byte-lane write port and reads it on a combinational read port. The interrupt lines pass through a configurable synchronizer before they reach the pending bits.

Pending bits clear on a written 1, and the enable bits share a byte lane with them, so a read-modify-write of the top byte must put 0 in the pending field. Writing 1s there would acknowledge every pending line.

Top module: `intx_ctrl_reg`

## Requirements
- R1: After reset the whole word reads 0x0000_0000 and `irq_out` is low.
- R2: When a line is high at the synchronizer output (`SYNC_STAGES` clocks after it is high at `intx_in`), its pending bit is set on the next clock, even if the line's enable is 0. Pending bit 28 is INTA, 29 INTB, 30 INTC and 31 INTD.
- R3: A write with byte lane 3 enabled and a 1 in a pending bit clears that bit, unless its synchronized line is still high. In that case the bit stays set. Writing 0 to a pending bit leaves it unchanged.
- R4: Bits 25:22 are read/write enables, with bit 22 for INTA and bit 25 for INTD. They change only on a write.
- R5: `irq_out` goes high one clock after some pending bit and its matching enable are both 1. It goes low one clock after no such pair remains.
- R6: Bits 27:26 (command-error and parity-error enables), bits 21:16 (six bus-error enables) and bits 14:8 (priorities for request lines 6..0) are read/write storage and have no effect on `irq_out`.
- R7: Bits 15 and 7:0 always read 0, whatever is written to them.
- R8: Each `reg_be` bit gates one byte (bit n covers data bits 8n+7:8n). Bytes whose lane is off are not written, and a pending bit is cleared only when lane 3 is on.
- R9: A write of 0xF000_0000 with lanes 3 and 2 enabled clears every pending bit whose line is low and disables all four lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_be | input | 4 | Byte-lane enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current word, read combinationally |
| intx_in | input | 4 | Interrupt lines, active high; bit 0 is INTA |
| irq_out | output | 1 | Combined interrupt to the parent controller |

## Verification
The bench builds the block with its default parameters: a 32-bit word and a two-stage synchronizer. The two stages make the line-to-pending latency an observable two-clock window. In that window a pulse of one clock still has to leave its pending bit set, and a clear written while the delayed line is still high has to lose. Random line activity, random byte lanes and random data run alongside the directed sequences. These cover partial-lane acknowledges and writes that disturb the enables in the shared top byte.

// File: rtl/intx_reg_pkg.sv
package intx_reg_pkg;
   localparam int NLINES   = 4;
   localparam int STS_LSB  = 28;
   localparam int EN_LSB   = 22;
   localparam int CLR_LANE = STS_LSB / 8;
   // writable bits: enables, error enables, request priorities
   localparam logic [31:0] RW_MASK = 32'h0FFF_7F00;
endpackage

// File: rtl/intx_line_sync.sv
module intx_line_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
            end else begin
               stage_q[0] <= d;
               for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
            end
         end
         assign q = stage_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/intx_sts_bit.sv
module intx_sts_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic line,
   input  logic clr,
   output logic sts
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts <= 1'b0;
      else        sts <= line | (sts & ~clr);
   end

   AST_STS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      line |=> sts); // R2
   AST_STS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !line) |=> !sts); // R3
   AST_STS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (sts && !clr) |=> sts); // R3
endmodule

// File: rtl/intx_cfg_store.sv
module intx_cfg_store #(
   parameter int                DATA_W  = 32,
   parameter logic [DATA_W-1:0] RW_MASK = '1,
   localparam int               NB      = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [NB-1:0]     be,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   logic [DATA_W-1:0] lane_m;
   logic [DATA_W-1:0] wr_m;

   genvar g;
   generate
      for (g = 0; g < NB; g++) begin : g_lane
         assign lane_m[g*8 +: 8] = {8{be[g]}};
      end
   endgenerate

   assign wr_m = lane_m & RW_MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (wr) q <= (q & ~wr_m) | (wdata & wr_m);
   end

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(q)); // R4
endmodule

// File: rtl/intx_ctrl_reg.sv
module intx_ctrl_reg
   import intx_reg_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2,
   localparam int NB         = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [NB-1:0]     reg_be,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NLINES-1:0] intx_in,
   output logic              irq_out
);
   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("intx_ctrl_reg: DATA_W must be 32");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("intx_ctrl_reg: SYNC_STAGES must not exceed 4");
      end
   endgenerate

   logic [NLINES-1:0] line_s;
   logic [NLINES-1:0] sts;
   logic [NLINES-1:0] clr;
   logic [NLINES-1:0] en;
   logic [DATA_W-1:0] cfg_q;
   logic              irq_q;

   intx_line_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(intx_in), .q(line_s));

   intx_cfg_store #(.DATA_W(DATA_W), .RW_MASK(RW_MASK)) cfg_i (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .be(reg_be),
      .wdata(reg_wdata), .q(cfg_q));

   genvar i;
   generate
      for (i = 0; i < NLINES; i++) begin : g_line
         assign clr[i] = reg_wr & reg_be[CLR_LANE] & reg_wdata[STS_LSB+i];
         intx_sts_bit sts_i (
            .clk(clk), .rst_n(rst_n), .line(line_s[i]),
            .clr(clr[i]), .sts(sts[i]));
      end
   endgenerate

   assign en = cfg_q[EN_LSB +: NLINES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(sts & en);
   end

   assign irq_out   = irq_q;
   assign reg_rdata = cfg_q | ({{(DATA_W-NLINES){1'b0}}, sts} << STS_LSB);

   AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (|(sts & en)) |=> irq_out); // R5
   AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(sts & en)) |=> !irq_out); // R5
endmodule

// File: tb/intx_ctrl_reg_tb_top.sv
`timescale 1ns/1ps
module intx_ctrl_reg_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_be = 4'h0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [3:0]  intx_in = 4'h0;
   logic        irq_out;

   always #2 clk = ~clk; // 250 MHz

   intx_ctrl_reg dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_be(reg_be),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .intx_in(intx_in), .irq_out(irq_out));

   int    n_tests = 0;
   int    n_fail  = 0;
   string cur_req = "R1";
   bit    done    = 1'b0;

   // reference model, behavioural
   logic [3:0]  m_sts = 0, m_s0 = 0, m_s1 = 0;
   logic [31:0] m_cfg = 0;
   logic        m_irq = 0;

   always @(posedge clk) begin
      logic [31:0] lm;
      logic [3:0]  clrv;
      if (!rst_n) begin
         m_sts = 0; m_s0 = 0; m_s1 = 0; m_cfg = 0; m_irq = 0;
      end else begin
         m_irq = |(m_sts & m_cfg[25:22]);
         clrv = (reg_wr && reg_be[3]) ? reg_wdata[31:28] : 4'h0;
         m_sts = m_s1 | (m_sts & ~clrv);
         if (reg_wr) begin
            lm = 0;
            for (int b = 0; b < 4; b++) if (reg_be[b]) lm |= 32'hFF << (8*b);
            lm &= 32'h0FFF_7F00;
            m_cfg = (m_cfg & ~lm) | (reg_wdata & lm);
         end
         m_s1 = m_s0; m_s0 = intx_in;
      end
   end

   always @(negedge clk) begin
      logic [31:0] exp_rd;
      if (!done) begin
         exp_rd = m_cfg | {m_sts, 28'h0};
         n_tests++;
         if (reg_rdata !== exp_rd) begin
            n_fail++;
            $display("FAIL %s rdata actual %h expected %h", cur_req, reg_rdata, exp_rd);
         end
         n_tests++;
         if (irq_out !== m_irq) begin
            n_fail++;
            $display("FAIL %s irq_out actual %b expected %b", cur_req, irq_out, m_irq);
         end
      end
   end

   task automatic idle(int n);
      for (int k = 0; k < n; k++) begin @(negedge clk); #1; end
   endtask

   task automatic wr(logic [3:0] be, logic [31:0] d);
      @(negedge clk); #1;
      reg_wr = 1'b1; reg_be = be; reg_wdata = d;
      @(negedge clk); #1;
      reg_wr = 1'b0; reg_be = 4'h0; reg_wdata = '0;
   endtask

   task automatic lines(logic [3:0] v);
      @(negedge clk); #1; intx_in = v;
   endtask

   initial begin
      cur_req = "R1";
      idle(3);
      rst_n = 1'b1;
      idle(3);
      // R2: single-cycle pulses on INTA and INTC while masked
      cur_req = "R2";
      lines(4'b0101); lines(4'b0000); idle(5);
      // R4/R5: enable INTA and INTD, irq must follow INTA pending
      cur_req = "R4";
      wr(4'hF, 32'h0240_0000); idle(3);
      cur_req = "R5";
      lines(4'b1000); lines(4'b0000); idle(4);
      // R3: ack INTA keeping enables; hold INTC high and try to clear
      cur_req = "R3";
      wr(4'h8, 32'h1200_0000); idle(3);
      lines(4'b0100); idle(3);
      wr(4'h8, 32'h4200_0000); idle(2);
      lines(4'b0000); idle(3);
      wr(4'h8, 32'h4200_0000); idle(2);
      wr(4'h8, 32'h0200_0000); idle(2);
      // R6: storage-only fields, no irq effect
      cur_req = "R6";
      wr(4'hF, 32'h0C3F_7F00); idle(2);
      lines(4'b0010); lines(4'b0000); idle(4);
      // R7: unwritable bits read zero
      cur_req = "R7";
      wr(4'h7, 32'hFFFF_FFFF); idle(2);
      // R8: lane gating, status untouched without lane 3
      cur_req = "R8";
      wr(4'h4, 32'hFFFF_FFFF); idle(2);
      wr(4'h3, 32'hF000_0000); idle(2);
      wr(4'h1, 32'h0000_0000); idle(2);
      // R9: upper halfword mask-and-clear
      cur_req = "R9";
      wr(4'hF, 32'h03C0_0000);
      lines(4'b1111); lines(4'b0000); idle(4);
      wr(4'hC, 32'hF000_0000); idle(4);
      // random mix
      cur_req = "R3";
      for (int k = 0; k < 400; k++) begin
         @(negedge clk); #1;
         intx_in   = 4'($urandom);
         reg_wr    = ($urandom % 3) == 0;
         reg_be    = 4'($urandom);
         reg_wdata = $urandom;
      end
      @(negedge clk); #1;
      reg_wr = 1'b0; intx_in = 4'h0;
      idle(6);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #20000;
      if (!done) begin
         done = 1'b1;
         n_tests++; n_fail++;
         $display("FAIL watchdog %s expired actual hung expected finished", cur_req);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule